// File: doc/BRIEF.md
# Prescaled Multi-Compare PWM Timer

This block is a register-mapped pulse-width timer for a small system-on-chip. A single counter runs on the input clock. A four-bit scale setting chooses which window of that counter is compared against a bank of compare registers, so the period is a power of two selected by the scale rather than by a period register. Each compare register drives its own active-low output: the output is low while the scaled count is below the compare value and high otherwise, so a fully-low (100 %) duty cycle cannot be produced.

Software reaches the block through a plain 32-bit register bus with single-cycle writes and combinational reads. It can read the configuration, the raw count and the scaled count, and it can read and write each compare value. The counter can run continuously or for a single period. It can also restart early when the scaled count meets compare 0. Each channel has a pending flag with a sticky option, and a deglitch option holds an output high for the rest of a period once it has gone high. Register writes are not buffered. A write made partway through a period changes the waveform on the next cycle.

Top module: `pwm_timer`

## Requirements
- R1: After a synchronous active-high reset, the configuration, count and all compare registers read zero, the counter is stopped, every `pwm_n` bit is high and every `irq` bit is low.
- R2: Without the deglitch hold, `pwm_n[i]` is low exactly when the scaled count is below compare i. Compare 0 keeps the output high. The largest compare value still leaves the output high for one scaled step per period, so it is never low for a whole period.
- R3: While either enable bit is set, the raw count rises by one per clock. The scaled count is the raw count shifted right by the scale field (config bits 3:0), truncated to the compare width, and it reads at byte offset 0x10.
- R4: With both enable bits clear, the count holds its value.
- R5: With the zero-compare bit clear, the count returns to zero after the value whose lowest CMP_W+scale bits are all ones, giving a period of 2^(CMP_W+scale) clocks.
- R6: With the zero-compare bit (config bit 9) set, the count is zero on the cycle after the scaled count equals compare 0.
- R7: The one-period enable (config bit 13) runs the counter. Hardware clears that bit on the cycle the count restarts, and the count then stays at zero.
- R8: With sticky (config bit 8) clear, `irq[i]` shows whether the scaled count was at or above compare i on the previous running cycle.
- R9: With sticky set, a set `irq[i]` stays set until a configuration write. Every configuration write loads the pending flags from bits 28+i of the written data.
- R10: With deglitch (config bit 10) set, once `pwm_n[i]` goes high in a period it stays high until the count restarts, even if compare i is raised above the scaled count.
- R11: The configuration register sits at offset 0x00 with the continuous enable in bit 12. Unused configuration bits read zero. The raw count sits at 0x08 and is writable. Compare i sits at 0x20+4*i and keeps only its low CMP_W bits. Writes to the scaled-count offset have no effect, and unmapped offsets read zero.
- R12: A compare write takes effect on the cycle after it, even in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| pwm_n | output | NCH | Active-low channel outputs |
| irq | output | NCH | Per-channel pending flags |

## Verification
The bench builds the timer with a 4-bit compare width and a 19-bit counter. That makes one period 16 clocks at scale 0 and 128 clocks at scale 3. Whole periods can therefore be walked cycle by cycle at every scale from 0 to 3, with compare values that include zero, the maximum and points in between. The small width also brings the wrap, the zero-compare restart, the one-shot stop and the mid-period compare rewrites within a few dozen cycles each. In every one of these cases the bench computes the expected count, scaled count, pending flags and outputs arithmetically.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int SCALE_W      = 4;

    // configuration bit positions (decoded by software)
    localparam int BIT_STICKY   = 8;
    localparam int BIT_ZEROCMP  = 9;
    localparam int BIT_DEGLITCH = 10;
    localparam int BIT_ALWAYS   = 12;
    localparam int BIT_ONCE     = 13;
    localparam int PEND_LSB     = 28;

    // word indices of the register map
    localparam int WORD_CFG     = 0;
    localparam int WORD_COUNT   = 2;
    localparam int WORD_SCALED  = 4;
    localparam int WORD_CMP0    = 8;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic               sticky;
        logic               zerocmp;
        logic               deglitch;
        logic               en_always;
        logic               en_once;
    } cfg_t;

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 31,
    parameter int CMP_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               running,
    input  logic [SCALE_W-1:0] scale,
    input  logic               zerocmp,
    input  logic [CMP_W-1:0]   cmp0,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   count,
    output logic [CMP_W-1:0]   scaled,
    output logic               restart
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_q, st_d;
    logic [CNT_W-1:0] shifted;
    logic [CNT_W-1:0] win_mask;
    logic             period_end;
    logic             zc_hit;
    logic             unused_shift_hi;

    always_comb begin
        shifted = st_q.cnt >> scale;
        for (int b = 0; b < CNT_W; b++) begin
            win_mask[b] = (b < CMP_W + int'(scale));
        end
        period_end = ((st_q.cnt & win_mask) == win_mask);
        zc_hit     = zerocmp && (shifted[CMP_W-1:0] == cmp0);
        restart    = running && (period_end || zc_hit);

        st_d = st_q;
        if (running) begin
            st_d.cnt = restart ? '0 : st_q.cnt + 1'b1;
        end
        if (load) begin
            st_d.cnt = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count           = st_q.cnt;
    assign scaled          = shifted[CMP_W-1:0];
    assign unused_shift_hi = ^shifted;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp,
    input  logic             running,
    input  logic             restart,
    input  logic             deglitch,
    input  logic             sticky,
    input  logic             pend_wr,
    input  logic             pend_wval,
    output logic             pwm_n,
    output logic             pending
);

    typedef struct packed {
        logic held_high;
        logic pend;
    } ch_state_t;

    ch_state_t st_q, st_d;
    logic      hit;

    always_comb begin
        hit   = (scaled >= cmp);
        pwm_n = hit | (deglitch & st_q.held_high);

        st_d = st_q;
        if (running) begin
            if (restart)  st_d.held_high = 1'b0;
            else if (hit) st_d.held_high = 1'b1;
            st_d.pend = sticky ? (st_q.pend | hit) : hit;
        end
        if (pend_wr) begin
            st_d.pend = pend_wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pending = st_q.pend;

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 31,
    parameter int CMP_W  = 16,
    parameter int ADDR_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [CNT_W-1:0]           count,
    input  logic [CMP_W-1:0]           scaled,
    input  logic [NCH-1:0]             pending,
    input  logic                       once_done,
    output cfg_t                       cfg_q,
    output logic [NCH-1:0][CMP_W-1:0]  cmp_q,
    output logic                       cnt_load,
    output logic [CNT_W-1:0]           cnt_val,
    output logic                       pend_wr,
    output logic [NCH-1:0]             pend_wval
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] IDX_CFG    = WIDX_W'(WORD_CFG);
    localparam logic [WIDX_W-1:0] IDX_COUNT  = WIDX_W'(WORD_COUNT);
    localparam logic [WIDX_W-1:0] IDX_SCALED = WIDX_W'(WORD_SCALED);

    typedef struct packed {
        cfg_t                      cfg;
        logic [NCH-1:0][CMP_W-1:0] cmp;
    } reg_state_t;

    reg_state_t        st_q, st_d;
    logic              wr;
    logic [WIDX_W-1:0] widx;
    logic              cfg_wr;
    logic [31:0]       rd;
    logic              unused_bus;

    always_comb begin
        wr     = bus_sel && bus_we;
        widx   = bus_addr[ADDR_W-1:2];
        cfg_wr = wr && (widx == IDX_CFG);

        st_d = st_q;
        if (cfg_wr) begin
            st_d.cfg.scale     = bus_wdata[SCALE_W-1:0];
            st_d.cfg.sticky    = bus_wdata[BIT_STICKY];
            st_d.cfg.zerocmp   = bus_wdata[BIT_ZEROCMP];
            st_d.cfg.deglitch  = bus_wdata[BIT_DEGLITCH];
            st_d.cfg.en_always = bus_wdata[BIT_ALWAYS];
            st_d.cfg.en_once   = bus_wdata[BIT_ONCE];
        end else if (once_done) begin
            st_d.cfg.en_once = 1'b0;
        end
        for (int i = 0; i < NCH; i++) begin
            if (wr && (widx == WIDX_W'(WORD_CMP0 + i))) begin
                st_d.cmp[i] = bus_wdata[CMP_W-1:0];
            end
        end

        cnt_load  = wr && (widx == IDX_COUNT);
        cnt_val   = bus_wdata[CNT_W-1:0];
        pend_wr   = cfg_wr;
        pend_wval = bus_wdata[PEND_LSB +: NCH];

        rd = '0;
        if (widx == IDX_CFG) begin
            rd[SCALE_W-1:0]     = st_q.cfg.scale;
            rd[BIT_STICKY]      = st_q.cfg.sticky;
            rd[BIT_ZEROCMP]     = st_q.cfg.zerocmp;
            rd[BIT_DEGLITCH]    = st_q.cfg.deglitch;
            rd[BIT_ALWAYS]      = st_q.cfg.en_always;
            rd[BIT_ONCE]        = st_q.cfg.en_once;
            rd[PEND_LSB +: NCH] = pending;
        end else if (widx == IDX_COUNT) begin
            rd[CNT_W-1:0] = count;
        end else if (widx == IDX_SCALED) begin
            rd[CMP_W-1:0] = scaled;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (widx == WIDX_W'(WORD_CMP0 + i)) begin
                    rd[CMP_W-1:0] = st_q.cmp[i];
                end
            end
        end
        bus_rdata = bus_sel ? rd : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg_q      = st_q.cfg;
    assign cmp_q      = st_q.cmp;
    assign unused_bus = ^{bus_addr[1:0], bus_wdata};

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 31,
    parameter int CMP_W  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_n,
    output logic [NCH-1:0]    irq
);

    cfg_t                      cfg_q;
    logic [NCH-1:0][CMP_W-1:0] cmp_q;
    logic [CNT_W-1:0]          count_q;
    logic [CMP_W-1:0]          scaled;
    logic                      restart;
    logic                      running;
    logic                      cnt_load;
    logic [CNT_W-1:0]          cnt_val;
    logic                      pend_wr;
    logic [NCH-1:0]            pend_wval;
    logic [NCH-1:0]            pending;

    assign running = cfg_q.en_always | cfg_q.en_once;

    pwm_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .CMP_W(CMP_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count_q), .scaled(scaled), .pending(pending),
        .once_done(restart),
        .cfg_q(cfg_q), .cmp_q(cmp_q),
        .cnt_load(cnt_load), .cnt_val(cnt_val),
        .pend_wr(pend_wr), .pend_wval(pend_wval)
    );

    pwm_counter #(
        .CNT_W(CNT_W), .CMP_W(CMP_W)
    ) u_counter (
        .clk(clk), .rst(rst),
        .running(running), .scale(cfg_q.scale), .zerocmp(cfg_q.zerocmp),
        .cmp0(cmp_q[0]), .load(cnt_load), .load_val(cnt_val),
        .count(count_q), .scaled(scaled), .restart(restart)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(
            .CMP_W(CMP_W)
        ) u_ch (
            .clk(clk), .rst(rst),
            .scaled(scaled), .cmp(cmp_q[g]),
            .running(running), .restart(restart),
            .deglitch(cfg_q.deglitch), .sticky(cfg_q.sticky),
            .pend_wr(pend_wr), .pend_wval(pend_wval[g]),
            .pwm_n(pwm_n[g]), .pending(pending[g])
        );
    end

    assign irq = pending;

endmodule

// File: rtl/pwm_timer_checks.sv
module pwm_timer_checks
    import pwm_timer_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 31,
    parameter int CMP_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      running,
    input logic                      restart,
    input logic                      cnt_load,
    input logic                      pend_wr,
    input cfg_t                      cfg,
    input logic [CNT_W-1:0]          count,
    input logic [CMP_W-1:0]          scaled,
    input logic [NCH-1:0][CMP_W-1:0] cmp,
    input logic [NCH-1:0]            pending,
    input logic [NCH-1:0]            pwm_n
);

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (!running && !cnt_load) |=> (count == $past(count)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (running && !restart && !cnt_load) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_restart_to_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (restart && !cnt_load) |=> (count == '0));

    assert_once_self_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (restart && cfg.en_once && !pend_wr) |=> !cfg.en_once);

    assert_sticky_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg.sticky && !pend_wr) |=> ((pending & $past(pending)) == $past(pending)));

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assert_low_below_cmp_R2: assert property (@(posedge clk) disable iff (rst)
            !pwm_n[g] |-> (scaled < cmp[g]));
    end

endmodule

bind pwm_timer pwm_timer_checks #(
    .NCH(NCH), .CNT_W(CNT_W), .CMP_W(CMP_W)
) u_checks (
    .clk(clk), .rst(rst), .running(running), .restart(restart),
    .cnt_load(cnt_load), .pend_wr(pend_wr), .cfg(cfg_q),
    .count(count_q), .scaled(scaled), .cmp(cmp_q),
    .pending(pending), .pwm_n(pwm_n)
);

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;

    localparam int NCH    = 4;
    localparam int CNT_W  = 19;
    localparam int CMP_W  = 4;
    localparam int ADDR_W = 6;

    localparam logic [5:0] A_CFG = 6'h00;
    localparam logic [5:0] A_CNT = 6'h08;
    localparam logic [5:0] A_SCL = 6'h10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    pwm_n;
    logic [NCH-1:0]    irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_timer #(.NCH(NCH), .CNT_W(CNT_W), .CMP_W(CMP_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_n(pwm_n), .irq(irq)
    );

    function automatic logic [5:0] a_cmp(input int i);
        return 6'(32 + 4 * i);
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller stands at a falling edge; one clock passes
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_and_zero();
        wr(A_CFG, 32'h0);
        wr(A_CNT, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int cnt;
        int cmpv [NCH];

        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(A_CFG, v); check_eq("R1 cfg after reset", v, 0);
        rd(A_CNT, v); check_eq("R1 count after reset", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(a_cmp(i), v); check_eq("R1 compare after reset", v, 0);
        end
        check_eq("R1 pwm_n after reset", 32'(pwm_n), 32'hF);
        check_eq("R1 irq after reset", 32'(irq), 0);
        step(3);
        rd(A_CNT, v); check_eq("R1 counter stopped", v, 0);

        // R2 R3 R5 sweep over scales and compare sets
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                int period, bad_out, bad_scl, high1;
                if (p == 0) begin cmpv[0] = 0; cmpv[1] = 15; cmpv[2] = 5; cmpv[3] = 9; end
                else        begin cmpv[0] = 1; cmpv[1] = 15; cmpv[2] = 12; cmpv[3] = 3; end
                stop_and_zero();
                for (int i = 0; i < NCH; i++) wr(a_cmp(i), 32'(cmpv[i]));
                wr(A_CFG, 32'(s) | (32'h1 << 12));
                period = 16 << s;
                cnt = 0; bad_out = 0; bad_scl = 0; high1 = 0;
                for (int k = 0; k < 2 * period + 3; k++) begin
                    int sc;
                    sc = (cnt >> s) & 15;
                    rd(A_SCL, v);
                    if (v !== 32'(sc)) bad_scl++;
                    for (int i = 0; i < NCH; i++) begin
                        if (pwm_n[i] !== (sc >= cmpv[i])) bad_out++;
                    end
                    if (k < period && pwm_n[1]) high1++;
                    step(1);
                    cnt = (cnt + 1) % period;
                end
                check_eq("R2 outputs over two periods (mismatches)", 32'(bad_out), 0);
                check_eq("R3 R5 scaled count over two periods (mismatches)", 32'(bad_scl), 0);
                check_eq("R2 max compare still high one step", 32'(high1), 32'(1 << s));
                rd(A_CNT, v); check_eq("R3 raw count tracks", v, 32'(cnt));
            end
        end

        // R4 stopped counter holds
        wr(A_CFG, 32'h0);
        rd(A_CNT, v); step(5); rd(A_CNT, v2);
        check_eq("R4 count holds while stopped", v2, v);

        // R6 zero-compare restart, scale 1, compare0 = 5
        stop_and_zero();
        wr(a_cmp(0), 32'd5);
        wr(A_CFG, 32'h1 | (32'h1 << 9) | (32'h1 << 12));
        begin
            int bad;
            cnt = 0; bad = 0;
            for (int k = 0; k < 40; k++) begin
                rd(A_CNT, v);
                if (v !== 32'(cnt)) bad++;
                step(1);
                cnt = (((cnt >> 1) & 15) == 5) ? 0 : cnt + 1;
            end
            check_eq("R6 zero-compare restart sequence (mismatches)", 32'(bad), 0);
        end

        // R7 one-period run
        stop_and_zero();
        wr(A_CFG, 32'h1 << 13);
        step(5);
        rd(A_CNT, v); check_eq("R7 one-shot counting", v, 5);
        step(20);
        rd(A_CNT, v); check_eq("R7 one-shot stopped at zero", v, 0);
        rd(A_CFG, v); check_eq("R7 one-shot bit cleared", v & (32'h1 << 13), 0);

        // R8 non-sticky pending
        stop_and_zero();
        cmpv[0] = 0; cmpv[1] = 8; cmpv[2] = 12; cmpv[3] = 3;
        for (int i = 0; i < NCH; i++) wr(a_cmp(i), 32'(cmpv[i]));
        wr(A_CFG, 32'h1 << 12);
        step(1);
        cnt = 1;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                for (int i = 0; i < NCH; i++) begin
                    if (irq[i] !== (((cnt + 15) % 16) >= cmpv[i])) bad++;
                end
                step(1);
                cnt = (cnt + 1) % 16;
            end
            check_eq("R8 pending follows comparator (mismatches)", 32'(bad), 0);
        end

        // R9 sticky pending
        stop_and_zero();
        wr(A_CFG, (32'h1 << 12) | (32'h1 << 8));
        step(20);
        check_eq("R9 sticky pending held after wrap", 32'(irq[2]), 1);
        wr(A_CFG, 32'h1 << 8);
        check_eq("R9 config write clears pending", 32'(irq), 0);
        wr(A_CFG, (32'h1 << 8) | (32'h1 << 30));
        check_eq("R9 config write loads pending", 32'(irq), 32'h4);
        rd(A_CFG, v); check_eq("R11 cfg readback with pending", v, 32'h4000_0100);

        // R10 deglitch hold
        stop_and_zero();
        wr(a_cmp(3), 32'd4);
        wr(A_CFG, (32'h1 << 12) | (32'h1 << 10));
        step(6);
        check_eq("R10 output high past compare", 32'(pwm_n[3]), 1);
        wr(a_cmp(3), 32'd10);
        check_eq("R10 deglitch keeps output high", 32'(pwm_n[3]), 1);
        step(11);
        check_eq("R10 hold released next period", 32'(pwm_n[3]), 0);

        // R12 unbuffered compare write
        stop_and_zero();
        wr(a_cmp(3), 32'd4);
        wr(A_CFG, 32'h1 << 12);
        step(6);
        check_eq("R12 output high before rewrite", 32'(pwm_n[3]), 1);
        wr(a_cmp(3), 32'd10);
        check_eq("R12 new compare applies next cycle", 32'(pwm_n[3]), 0);

        // R11 register map
        wr(A_CFG, 32'h0);
        wr(A_CFG, 32'hFFFF_CFFF);
        rd(A_CFG, v); check_eq("R11 cfg unused bits zero", v, 32'hF000_070F);
        rd(6'h04, v); check_eq("R11 unmapped offset 0x04", v, 0);
        rd(6'h3C, v); check_eq("R11 unmapped offset 0x3C", v, 0);
        wr(a_cmp(1), 32'hFFFF);
        rd(a_cmp(1), v); check_eq("R11 compare width", v, 32'hF);
        wr(A_CNT, 32'h123);
        rd(A_CNT, v); check_eq("R11 count writable", v, 32'h123);
        wr(A_SCL, 32'h7777);
        rd(A_CNT, v); check_eq("R11 scaled write ignored (count)", v, 32'h123);
        rd(A_SCL, v); check_eq("R11 scaled write ignored (scaled)", v, 32'h0);
        wr(A_CFG, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule